// File: doc/BRIEF.md
# Keyboard Event Port

This block is the CPU-facing side of a scanned keyboard. It takes up a single byte-wide I/O location. A bus write to that location loads an 8-bit configuration word. The word holds the key-up debounce reload count, which goes to the debouncer, and a blanking flag. While the flag is set, the key matrix reads every key as released. A bus read from the same location pops the oldest key event from a 256-entry event queue. The debouncer fills that queue, and an active-low interrupt line stays low for as long as the queue holds something.

Setting the blanking flag rebuilds the CPU's picture of the keyboard. The flag drains the queue and holds it empty, so the key-up events that blanking produces are thrown away. Once the flag is cleared, keys still held are scanned again and arrive as fresh key-down events. Global reset sets the flag, so the same rebuild happens at power-up. When the queue is full, new events are dropped and the stored ones are kept.

Top module: `kbd_port_if`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it is released, `scan_blank` is 1, `cfg_reload` is 10, `irq_n` is 1 and `bus_rdata` is 0x00.
- R2: A write strobe loads `bus_wdata` into the configuration word on that clock edge. Bit 7 appears on `scan_blank` and bits 6:0 appear on `cfg_reload` from the next cycle.
- R3: While `scan_blank` is 1, the queue is held empty. Stored events are discarded, pushes are dropped, `irq_n` is 1 and reads return 0x00. After the flag clears, the queue is still empty.
- R4: A read strobe loads the oldest stored event onto `bus_rdata` on that clock edge and removes it. Events come out in the order they were pushed.
- R5: `irq_n` is 0 exactly when the queue holds at least one event and `scan_blank` is 0. It changes in the cycle after the push or pop that changes the queue's occupancy.
- R6: The queue holds 256 events. A push while it is full, with no read in the same cycle, is dropped and leaves the stored events intact.
- R7: A read while the queue is empty returns 0x00 and removes nothing.
- R8: A push and a read in the same cycle are both carried out. This holds when the queue is partly filled, when it is full (the push is then accepted), and when it is empty (the read returns 0x00 and the pushed event is stored).
- R9: `bus_rdata` keeps its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low, asynchronous |
| bus_wr | input | 1 | Write strobe for the I/O location |
| bus_rd | input | 1 | Read strobe for the I/O location |
| bus_wdata | input | 8 | Write data: bit 7 blanking flag, bits 6:0 debounce reload |
| evt_push | input | 1 | Debouncer event strobe |
| evt_data | input | 8 | Event byte (bit 7 direction, bits 6:0 key code) |
| bus_rdata | output | 8 | Byte returned by the most recent read |
| irq_n | output | 1 | Interrupt request, active low, queue not empty |
| cfg_reload | output | 7 | Debounce reload count to the debouncer |
| scan_blank | output | 1 | Blanking flag to the key matrix |

## Verification
A wrong occupancy state shows within one cycle on `irq_n`. An empty queue that believes it is filled pulls the interrupt low; a filled one that believes it is empty hides stored events. A stale pointer shows on the next read, when `bus_rdata` returns a byte out of order or a repeat. A drain of a full queue against a value computed from the push index exposes every slot. If dropping on full fails, the oldest entry is overwritten, and this shows up at the first read after the overflow.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;

    localparam int RELOAD_W = 7;
    localparam logic [RELOAD_W-1:0] RELOAD_DEFAULT = 7'd10;

    typedef struct packed {
        logic                blank;
        logic [RELOAD_W-1:0] reload;
    } kbd_cfg_t;

    typedef enum logic [1:0] {
        FQ_HELD,
        FQ_EMPTY,
        FQ_PART,
        FQ_FULL
    } fq_state_e;

endpackage

// File: rtl/kbd_cfg_reg.sv
module kbd_cfg_reg
    import kbd_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  kbd_cfg_t wdata,
    output kbd_cfg_t cfg_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.blank  <= 1'b1;
            cfg_q.reload <= RELOAD_DEFAULT;
        end else if (wr_en) begin
            cfg_q <= wdata;
        end
    end

endmodule

// File: rtl/kbd_evt_store.sv
module kbd_evt_store #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/kbd_fifo_ctrl.sv
module kbd_fifo_ctrl
    import kbd_port_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          do_push,
    output logic          do_pop,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          nonempty
);

    fq_state_e     state_q, state_d;
    logic [CW-1:0] count_q, count_d;
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic          is_empty, is_full;

    // Output decode of the occupancy state
    always_comb begin
        unique case (state_q)
            FQ_HELD:  begin is_empty = 1'b1; is_full = 1'b0; end
            FQ_EMPTY: begin is_empty = 1'b1; is_full = 1'b0; end
            FQ_PART:  begin is_empty = 1'b0; is_full = 1'b0; end
            FQ_FULL:  begin is_empty = 1'b0; is_full = 1'b1; end
        endcase
    end

    assign do_pop   = pop_req  && !hold && !is_empty;
    assign do_push  = push_req && !hold && (!is_full || do_pop);
    assign nonempty = !is_empty && !hold;
    assign count_d  = count_q + CW'(do_push) - CW'(do_pop);

    // Transition selection
    always_comb begin
        if (hold) begin
            state_d = FQ_HELD;
        end else if (count_d == '0) begin
            state_d = FQ_EMPTY;
        end else if (count_d == CW'(DEPTH)) begin
            state_d = FQ_FULL;
        end else begin
            state_d = FQ_PART;
        end
    end

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= FQ_HELD;
            count_q  <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            state_q <= state_d;
            if (hold) begin
                count_q  <= '0;
                wr_ptr_q <= '0;
                rd_ptr_q <= '0;
            end else begin
                count_q <= count_d;
                if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
                if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
            end
        end
    end

    assign wr_ptr = wr_ptr_q;
    assign rd_ptr = rd_ptr_q;

endmodule

// File: rtl/kbd_port_if.sv
module kbd_port_if
    import kbd_port_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    input  logic       evt_push,
    input  logic [7:0] evt_data,
    output logic [7:0] bus_rdata,
    output logic       irq_n,
    output logic [6:0] cfg_reload,
    output logic       scan_blank
);

    kbd_cfg_t      cfg_q;
    logic          do_push, do_pop, nonempty;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [7:0]    head_byte;
    logic [7:0]    rdata_q;

    kbd_cfg_reg i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .wdata (kbd_cfg_t'(bus_wdata)),
        .cfg_q (cfg_q)
    );

    kbd_fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (cfg_q.blank),
        .push_req (evt_push),
        .pop_req  (bus_rd),
        .do_push  (do_push),
        .do_pop   (do_pop),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .nonempty (nonempty)
    );

    kbd_evt_store #(.DEPTH(DEPTH), .DW(8)) i_store (
        .clk   (clk),
        .we    (do_push),
        .waddr (wr_ptr),
        .wdata (evt_data),
        .raddr (rd_ptr),
        .rdata (head_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= do_pop ? head_byte : 8'h00;
        end
    end

    assign bus_rdata  = rdata_q;
    assign irq_n      = !nonempty;
    assign cfg_reload = cfg_q.reload;
    assign scan_blank = cfg_q.blank;

endmodule

// File: rtl/kbd_port_chk.sv
module kbd_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic       evt_push,
    input logic [7:0] bus_rdata,
    input logic       irq_n,
    input logic [6:0] cfg_reload,
    input logic       scan_blank
);

    AST_WR_LOADS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> ({scan_blank, cfg_reload} == $past(bus_wdata))); // R2

    AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        scan_blank |-> irq_n); // R3

    AST_IRQ_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && !scan_blank && evt_push && !bus_wr) |=> !irq_n); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !bus_rd && !bus_wr) |=> !irq_n); // R5

    AST_EMPTY_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && irq_n) |=> (bus_rdata == 8'h00)); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R9

endmodule

bind kbd_port_if kbd_port_chk i_kbd_port_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .evt_push   (evt_push),
    .bus_rdata  (bus_rdata),
    .irq_n      (irq_n),
    .cfg_reload (cfg_reload),
    .scan_blank (scan_blank)
);

// File: tb/test_kbd_port_if.sv
module test_kbd_port_if;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       evt_push = 1'b0;
    logic [7:0] evt_data = '0;
    logic [7:0] bus_rdata;
    logic       irq_n;
    logic [6:0] cfg_reload;
    logic       scan_blank;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    kbd_port_if i_kbd_port_if (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .evt_push   (evt_push),
        .evt_data   (evt_data),
        .bus_rdata  (bus_rdata),
        .irq_n      (irq_n),
        .cfg_reload (cfg_reload),
        .scan_blank (scan_blank)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One bus cycle: inputs sampled at the posedge, outputs observed at the negedge after it
    task automatic cyc(input bit wr, input bit rd, input logic [7:0] wd,
                       input bit push, input logic [7:0] ed);
        bus_wr = wr; bus_rd = rd; bus_wdata = wd; evt_push = push; evt_data = ed;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; evt_push = 1'b0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 values during reset
        chk("R1 blank", scan_blank, 1);
        chk("R1 reload", cfg_reload, 10);
        chk("R1 irq_n", irq_n, 1);
        chk("R1 rdata", bus_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 blank after release", scan_blank, 1);
        chk("R1 irq_n after release", irq_n, 1);

        // R3: pushes while blanked are dropped
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 8'hA0 + 8'(i));
        chk("R3 irq_n while blanked", irq_n, 1);
        cyc(0, 1, 0, 0, 0);
        chk("R3 read while blanked", bus_rdata, 0);

        // R2: configuration write
        cyc(1, 0, 8'h05, 0, 0);
        chk("R2 reload", cfg_reload, 5);
        chk("R2 blank", scan_blank, 0);
        chk("R3 nothing kept after blank", irq_n, 1);

        // R7: empty read
        cyc(0, 1, 0, 0, 0);
        chk("R7 empty read", bus_rdata, 0);

        // R5/R4: single event
        cyc(0, 0, 0, 1, 8'h9C);
        chk("R5 irq_n after push", irq_n, 0);
        cyc(0, 1, 0, 0, 0);
        chk("R4 single read", bus_rdata, 8'h9C);
        chk("R5 irq_n after pop", irq_n, 1);
        cyc(0, 0, 0, 0, 0);
        chk("R9 rdata held", bus_rdata, 8'h9C);

        // R6: fill to capacity then overflow
        for (int i = 0; i < 256; i++) cyc(0, 0, 0, 1, pat(i));
        chk("R5 irq_n when full", irq_n, 0);
        cyc(0, 0, 0, 1, 8'hEE);
        chk("R9 rdata held across pushes", bus_rdata, 8'h9C);
        // R8: push plus read on a full queue
        cyc(0, 1, 0, 1, 8'h77);
        chk("R8 read on full", bus_rdata, pat(0));
        for (int i = 1; i < 256; i++) begin
            cyc(0, 1, 0, 0, 0);
            chk("R6 drain order", bus_rdata, pat(i));
        end
        chk("R6 last entry still pending", irq_n, 0);
        cyc(0, 1, 0, 0, 0);
        chk("R8 push accepted on full", bus_rdata, 8'h77);
        chk("R5 irq_n drained", irq_n, 1);
        cyc(0, 1, 0, 0, 0);
        chk("R7 read after drain", bus_rdata, 0);

        // R8: push plus read on empty queue
        cyc(0, 1, 0, 1, 8'h33);
        chk("R8 read on empty", bus_rdata, 0);
        chk("R8 push kept on empty", irq_n, 0);
        cyc(0, 1, 0, 0, 0);
        chk("R8 stored on empty", bus_rdata, 8'h33);

        // R8: partial queue
        cyc(0, 0, 0, 1, 8'h01);
        cyc(0, 0, 0, 1, 8'h02);
        cyc(0, 1, 0, 1, 8'h03);
        chk("R8 partial read", bus_rdata, 8'h01);
        cyc(0, 1, 0, 0, 0);
        chk("R4 order 2", bus_rdata, 8'h02);
        cyc(0, 1, 0, 0, 0);
        chk("R4 order 3", bus_rdata, 8'h03);
        chk("R5 empty again", irq_n, 1);

        // R3: flush by blanking flag
        cyc(0, 0, 0, 1, 8'h44);
        cyc(0, 0, 0, 1, 8'h55);
        chk("R5 irq before flush", irq_n, 0);
        cyc(1, 0, 8'h8C, 0, 0);
        chk("R2 blank set", scan_blank, 1);
        chk("R2 reload 12", cfg_reload, 12);
        chk("R3 irq_n on blank", irq_n, 1);
        cyc(0, 1, 0, 1, 8'h66);
        chk("R3 read while blank", bus_rdata, 0);
        cyc(1, 0, 8'h0C, 0, 0);
        chk("R3 blank cleared", scan_blank, 0);
        chk("R3 queue empty after flush", irq_n, 1);
        cyc(0, 1, 0, 0, 0);
        chk("R3 stored events discarded", bus_rdata, 0);

        summary();
    end

endmodule